// File: doc/BRIEF.md
# Write-Enable Latch and Protection Controller

This block sits behind the byte-level decoder of a serial front end for a clock and EEPROM device. For every transaction the front end reports a start, which target each data byte is for (the status register, the clock/control registers or the memory array), the byte address, the data byte, and then either a stop or an abort. The block decides at once whether the byte is accepted and acknowledged. Writes that were accepted take effect only when a clean stop closes the transaction.

The block holds two volatile write-enable latches and a power-fail flag, and reports all three through a status byte. Control-register writes are gated behind a two-step unlock. A status write of 02h arms the general latch. A later status write of 06h arms the register latch. Array writes are checked against a three-bit block-protect code supplied by the nonvolatile store. A committed control-register or array write launches a nonvolatile cycle of a fixed, parameterized number of cycles. While that cycle runs, every write is refused.

Top module: `wr_protect_ctrl`

## Requirements
- R1: After reset, status_o reads 01h: bit 0 is the power-fail flag and reads 1, bit 1 is the general latch and reads 0, bit 2 is the register latch and reads 0. busy_o is 0.
- R2: A status write of 02h, closed by a stop, sets status bit 1 and leaves bit 2 unchanged. The data byte is acknowledged.
- R3: A status write of 06h sets bit 2 only when bit 1 is already 1; otherwise it has no effect. Any status value other than 00h, 02h and 06h leaves both latches unchanged. Bit 2 is never 1 while bit 1 is 0.
- R4: A status write of 00h clears both bit 1 and bit 2.
- R5: While bit 1 is 0, data bytes for target 1 (control registers) or target 2 (array) are not acknowledged, and a following stop starts no nonvolatile cycle.
- R6: A control-register byte is acknowledged only when bits 1 and 2 are both 1. A stop then raises busy_o, and nv_start_o pulses for one cycle. busy_o stays high for exactly BUSY_CYC cycles. When it falls, bit 2 is cleared and bit 1 is kept.
- R7: A start or an abort that arrives before the stop discards the pending write. No cycle starts, and the latches keep their values.
- R8: Status bit 0 is cleared by the first committed control-register write. No status write can set it.
- R9: Status bits 3 to 7 always read 0.
- R10: Array bytes that fall in the range selected by bp_i are not acknowledged. With 11 address bits and 64-byte pages the ranges are: 000 none; 001 600h-7FFh; 010 400h-7FFh; 011 all; 100 000h-03Fh; 101 000h-07Fh; 110 000h-0FFh; 111 000h-1FFh.
- R11: While busy_o is 1, no byte to any target is acknowledged.
- R12: A committed array write runs the same busy period, but the register latch (bit 2) survives its end.
- R13: A transaction with no data bytes, such as a read, leaves the latches unchanged. It does not break the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus; commits the pending write |
| abort_i | input | 1 | Transaction broken (wrong bit count) |
| byte_vld_i | input | 1 | A data byte is present this cycle |
| tgt_i | input | 2 | Target: 0 status, 1 control registers, 2 array |
| addr_i | input | AW | Byte address of the data byte |
| byte_i | input | 8 | Data byte |
| bp_i | input | 3 | Block-protect code |
| ack_o | output | 1 | Acknowledge for the current data byte |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Nonvolatile cycle in progress |
| nv_start_o | output | 1 | One-cycle pulse when a nonvolatile cycle begins |

## Verification
The bench builds the block with AW=11, PAGE_W=6 and BUSY_CYC=16. An 11-bit address with 64-byte pages puts every protect-range edge, at 03Fh/040h, 07Fh/080h, 0FFh/100h, 1FFh/200h, 3FFh/400h and 5FFh/600h, within reach of single probes. A 16-cycle busy period is short enough to count exactly. It is also long enough to fit refused status and array writes inside it.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [1:0] TGT_SR  = 2'd0;
  localparam logic [1:0] TGT_CCR = 2'd1;
  localparam logic [1:0] TGT_ARR = 2'd2;

  localparam logic [7:0] SR_CMD_CLR  = 8'h00;
  localparam logic [7:0] SR_CMD_WEL  = 8'h02;
  localparam logic [7:0] SR_CMD_BOTH = 8'h06;
endpackage

// File: rtl/wp_protect.sv
module wp_protect #(
  parameter int AW     = 11,
  parameter int PAGE_W = 6
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    bp_i,
  output logic          prot_o
);
  logic [AW-1:0] low_hi;

  // first 1, 2, 4 or 8 pages
  assign low_hi = addr_i >> (PAGE_W + int'(bp_i[1:0]));

  always_comb begin
    unique case (bp_i)
      3'b000:  prot_o = 1'b0;
      3'b001:  prot_o = &addr_i[AW-1:AW-2];
      3'b010:  prot_o = addr_i[AW-1];
      3'b011:  prot_o = 1'b1;
      default: prot_o = (low_hi == '0);
    endcase
  end
endmodule

// File: rtl/wp_latches.sv
module wp_latches
  import wp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_wr_i,
  input  logic [7:0] sr_val_i,
  input  logic       ccr_commit_i,
  input  logic       ccr_done_i,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       rtcf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
      rtcf_o <= 1'b1;
    end else begin
      if (sr_wr_i) begin
        unique case (sr_val_i)
          SR_CMD_CLR: begin
            wel_o  <= 1'b0;
            rwel_o <= 1'b0;
          end
          SR_CMD_WEL:  wel_o <= 1'b1;
          SR_CMD_BOTH: if (wel_o) rwel_o <= 1'b1;
          default: ;
        endcase
      end
      if (ccr_done_i)   rwel_o <= 1'b0;
      if (ccr_commit_i) rtcf_o <= 1'b0;
    end
  end

  p_rwel_implies_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_o |-> wel_o);

  p_rtcf_never_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rtcf_o));
endmodule

// File: rtl/wp_nv_timer.sv
module wp_nv_timer #(
  parameter int BUSY_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ccr_i,
  output logic busy_o,
  output logic nv_start_o,
  output logic ccr_done_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          kind_ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      kind_ccr_q <= 1'b0;
      nv_start_o <= 1'b0;
    end else begin
      nv_start_o <= start_i && !busy_o;
      if (start_i && !busy_o) begin
        busy_o     <= 1'b1;
        cnt_q      <= CW'(BUSY_CYC - 1);
        kind_ccr_q <= ccr_i;
      end else if (busy_o) begin
        if (cnt_q == '0) busy_o <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign ccr_done_o = busy_o && (cnt_q == '0) && kind_ccr_q;

  p_start_sets_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  p_no_start_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/wr_protect_ctrl.sv
module wr_protect_ctrl
  import wp_pkg::*;
#(
  parameter int AW       = 11,
  parameter int PAGE_W   = 6,
  parameter int BUSY_CYC = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          abort_i,
  input  logic          byte_vld_i,
  input  logic [1:0]    tgt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    byte_i,
  input  logic [2:0]    bp_i,
  output logic          ack_o,
  output logic [7:0]    status_o,
  output logic          busy_o,
  output logic          nv_start_o
);
  logic       prot, wel, rwel, rtcf, accept;
  logic       pend_sr_q, pend_nv_q, pend_ccr_q;
  logic [7:0] pend_val_q;
  logic       commit_sr, commit_nv, ccr_done;

  wp_protect #(.AW(AW), .PAGE_W(PAGE_W)) i_protect (
    .addr_i (addr_i),
    .bp_i   (bp_i),
    .prot_o (prot)
  );

  always_comb begin
    unique case (tgt_i)
      TGT_SR:  accept = !busy_o;
      TGT_CCR: accept = !busy_o && wel && rwel;
      TGT_ARR: accept = !busy_o && wel && !prot;
      default: accept = 1'b0;
    endcase
  end

  assign ack_o = byte_vld_i && accept;

  // writes stay pending until a clean stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_sr_q  <= 1'b0;
      pend_nv_q  <= 1'b0;
      pend_ccr_q <= 1'b0;
      pend_val_q <= '0;
    end else if (start_i || abort_i || stop_i) begin
      pend_sr_q  <= 1'b0;
      pend_nv_q  <= 1'b0;
      pend_ccr_q <= 1'b0;
    end else if (ack_o) begin
      if (tgt_i == TGT_SR) begin
        pend_sr_q  <= 1'b1;
        pend_val_q <= byte_i;
      end else begin
        pend_nv_q  <= 1'b1;
        pend_ccr_q <= pend_ccr_q | (tgt_i == TGT_CCR);
      end
    end
  end

  assign commit_sr = stop_i && pend_sr_q;
  assign commit_nv = stop_i && pend_nv_q;

  wp_latches i_latches (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_wr_i      (commit_sr),
    .sr_val_i     (pend_val_q),
    .ccr_commit_i (commit_nv && pend_ccr_q),
    .ccr_done_i   (ccr_done),
    .wel_o        (wel),
    .rwel_o       (rwel),
    .rtcf_o       (rtcf)
  );

  wp_nv_timer #(.BUSY_CYC(BUSY_CYC)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit_nv),
    .ccr_i      (pend_ccr_q),
    .busy_o     (busy_o),
    .nv_start_o (nv_start_o),
    .ccr_done_o (ccr_done)
  );

  assign status_o = {5'b0, rwel, wel, rtcf};

  p_nack_wel_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && tgt_i != TGT_SR && !status_o[1]) |-> !ack_o);

  p_nack_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o);

  p_full_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && tgt_i == TGT_ARR && bp_i == 3'b011) |-> !ack_o);
endmodule

// File: tb/test_wr_protect_ctrl.sv
`timescale 1ns/1ps
module test_wr_protect_ctrl;
  localparam int AW = 11;
  localparam int BUSY = 16;

  typedef struct packed {
    logic [2:0]    bp;
    logic [AW-1:0] addr;
    logic          ack;
  } probe_t;

  localparam probe_t PROBES [15] = '{
    '{3'b000, 11'h7FF, 1'b1}, '{3'b001, 11'h5FF, 1'b1}, '{3'b001, 11'h600, 1'b0},
    '{3'b001, 11'h7FF, 1'b0}, '{3'b010, 11'h3FF, 1'b1}, '{3'b010, 11'h400, 1'b0},
    '{3'b011, 11'h000, 1'b0}, '{3'b100, 11'h03F, 1'b0}, '{3'b100, 11'h040, 1'b1},
    '{3'b101, 11'h07F, 1'b0}, '{3'b101, 11'h080, 1'b1}, '{3'b110, 11'h0FF, 1'b0},
    '{3'b110, 11'h100, 1'b1}, '{3'b111, 11'h1FF, 1'b0}, '{3'b111, 11'h200, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, abort = 0, bvld = 0;
  logic [1:0] tgt = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] data = 0;
  logic [2:0] bp = 0;
  logic ack, busy, nvs;
  logic [7:0] status;
  int errors = 0, checks = 0, nv_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wr_protect_ctrl #(.AW(AW), .PAGE_W(6), .BUSY_CYC(BUSY)) i_wr_protect_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .abort_i(abort),
    .byte_vld_i(bvld), .tgt_i(tgt), .addr_i(addr), .byte_i(data), .bp_i(bp),
    .ack_o(ack), .status_o(status), .busy_o(busy), .nv_start_o(nvs));

  always @(negedge clk) if (nvs) nv_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic do_stop();  @(negedge clk); stop  = 1; @(negedge clk); stop  = 0; endtask
  task automatic do_abort(); @(negedge clk); abort = 1; @(negedge clk); abort = 0; endtask

  task automatic send(input logic [1:0] t, input logic [AW-1:0] a, input logic [7:0] d,
                      output logic got);
    @(negedge clk);
    tgt = t; addr = a; data = d; bvld = 1;
    #1 got = ack;
    @(negedge clk);
    bvld = 0;
  endtask

  task automatic sr_write(input logic [7:0] v, output logic got);
    do_start();
    send(2'd0, '0, v, got);
    do_stop();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h01);
    chk("R1 reset busy", busy, 0);

    sr_write(8'h02, a);
    chk("R2 ack 02h", a, 1);
    chk("R2 wel set", status, 8'h03);

    foreach (PROBES[i]) begin
      bp = PROBES[i].bp;
      do_start();
      send(2'd2, PROBES[i].addr, 8'hA5, a);
      chk($sformatf("R10 bp=%b addr=%h", PROBES[i].bp, PROBES[i].addr), a, PROBES[i].ack);
      do_abort();
    end
    bp = 3'b000;
    chk("R7 abort leaves idle", busy, 0);
    chk("R7 abort no cycle", nv_cnt, 0);

    do_start();
    send(2'd1, 11'h010, 8'h11, a);
    chk("R6 ccr nack without reg latch", a, 0);
    do_stop();
    chk("R6 no busy without reg latch", busy, 0);

    sr_write(8'h06, a);
    chk("R3 06h after 02h", status, 8'h07);
    do_start(); do_stop();
    chk("R13 empty txn keeps latches", status, 8'h07);
    sr_write(8'h04, a);
    chk("R3 other value ignored", status, 8'h07);
    chk("R9 high bits zero", status[7:3], 0);

    do_start();
    send(2'd1, 11'h010, 8'h22, a);
    chk("R6 ccr ack unlocked", a, 1);
    do_start();
    do_stop();
    chk("R7 restart drops ccr write", busy, 0);
    chk("R7 reg latch kept", status, 8'h07);

    do_start();
    send(2'd1, 11'h011, 8'h33, a);
    do_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R6 busy length", n, BUSY);
    chk("R6 nv_start pulse", nv_cnt, 1);
    chk("R6 R8 after ccr cycle", status, 8'h02);

    sr_write(8'h06, a);
    chk("R3 relock reg latch", status, 8'h06);
    do_start();
    send(2'd2, 11'h123, 8'h44, a);
    chk("R12 array ack", a, 1);
    do_stop();
    chk("R12 busy", busy, 1);
    do_start();
    send(2'd0, '0, 8'h00, a);
    chk("R11 status nack busy", a, 0);
    send(2'd2, 11'h124, 8'h55, a);
    chk("R11 array nack busy", a, 0);
    do_stop();
    while (busy) @(negedge clk);
    chk("R12 reg latch survives", status, 8'h06);
    chk("R11 single cycle run", nv_cnt, 2);

    sr_write(8'h01, a);
    chk("R8 flag not writable", status, 8'h06);
    sr_write(8'h00, a);
    chk("R4 clear both", status, 8'h00);

    do_start();
    send(2'd1, 11'h000, 8'h66, a);
    chk("R5 ccr nack wel low", a, 0);
    send(2'd2, 11'h300, 8'h77, a);
    chk("R5 array nack wel low", a, 0);
    do_stop();
    chk("R5 no cycle", busy, 0);
    sr_write(8'h06, a);
    chk("R3 06h without wel", status, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule